// File: doc/BRIEF.md
# Scanline Non-Maskable Interrupt Pulse Generator

This block raises a short active-low interrupt strobe toward the CPU at one fixed horizontal position of every scanline whose display instruction asked for an interrupt. The strobe goes out only when the CPU has set the enable bit. It ends by itself after a fixed number of cycles, with no acknowledge from the CPU. The CPU sees the request early enough to start interrupt entry at an instruction boundary shortly after the strobe begins.

The block samples the horizontal cycle counter and the per-line request flag. The CPU writes to it through a small write port with a one-bit address. Address 0 is the enable register, and only bit 7 of the written data is kept there. Address 1 is a strobe: any write to it clears the cause flag.

The cause flag is readable as an 8-bit status byte:
- Bit 7 marks a scanline interrupt.
- Bit 6 is kept for the frame-start source, which lives elsewhere, and reads 0 here.

Enable writes are checked at the decision point in a fixed way. If the bit is set during the cycle just before the trigger position, the current line's strobe is not lost. Instead it starts one cycle late.

Top module: `scanline_nmi_gen`

## Requirements
- R1: After synchronous reset, `nmi_n` is 1, `irq_status` is 0x00 and the enable bit is cleared, so a requested line produces no strobe until the enable bit is written.
- R2: With TRIGGER_CYCLE = T and PULSE_CYCLES = P, two conditions must both hold during the cycle in which `h_pos` equals T-1: the enable bit already holds 1, and `line_irq_req` is 1. When they do, `nmi_n` is 0 in exactly the cycles where `h_pos` runs from T to T+P-1, and 1 in the cycles on either side.
- R3: Suppose a write to address 0 with data bit 7 = 1 occurs in the cycle where `h_pos` equals T-1, while the enable bit was 0, and `line_irq_req` is 1 in the following cycle. Then the strobe of that line covers `h_pos` T+1 to T+P instead.
- R4: No strobe is produced on a line where the enable bit is 0 at the decision point, or where `line_irq_req` is 0. A disabling write made in the cycle at `h_pos` = T-1, or later, does not remove the current line's strobe.
- R5: A strobe lasts exactly P cycles whatever the enable bit or request do meanwhile. At most one strobe occurs per line, even with `line_irq_req` held at 1 for the whole line.
- R6: `irq_status` bit 7 reads 1 from the first low cycle of a strobe onward. Bits 6 to 0 always read 0.
- R7: A write to address 1 clears status bit 7 from the next cycle on. If a strobe starts in that same next cycle, the bit reads 1.
- R8: A write to address 0 loads only data bit 7 into the enable bit. Data bits 6 to 0 have no effect, so writing 0x7F leaves interrupts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per horizontal cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| h_pos | input | H_WIDTH | Current horizontal cycle within the line |
| line_irq_req | input | 1 | The current line's display instruction requests an interrupt |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_addr | input | 1 | 0 = enable register, 1 = clear status |
| cpu_wdata | input | 8 | Write data; bit 7 is the enable |
| nmi_n | output | 1 | Active-low interrupt strobe to the CPU |
| irq_status | output | 8 | Cause byte; bit 7 = scanline source, bit 6 = frame source (0 here) |

## Verification
The bench sweeps every combination of request level and prior enable state against each write kind: enable set, enable cleared, and status clear. Each write kind is placed at every cycle around the decision point. Every cycle of every line is compared with an arithmetic model.

The sweep is aimed at specific faults:
- A design that reads the enable bit after the write, rather than before it, would either fire at the trigger position or drop the late strobe.
- A design that re-arms while the request stays high would emit a second strobe.
- A counter that is off by one would widen or shorten the strobe by a cycle.
- Giving the clear priority over a coincident strobe would leave the status bit at 0 when a strobe had fired.

// File: rtl/scanline_nmi_pkg.sv
// Shared encodings for the scanline interrupt generator.
// Assumes: status and enable bytes are 8 bits wide.
package scanline_nmi_pkg;
    localparam int DATA_W        = 8;
    localparam int EN_LINE_BIT   = 7;  // enable bit inside the enable byte
    localparam int STAT_LINE_BIT = 7;  // scanline cause bit in the status byte
    localparam int STAT_FRAME_BIT = 6; // frame-start cause, driven by another block

    typedef enum logic {
        ADDR_ENABLE = 1'b0,
        ADDR_CLEAR  = 1'b1
    } wr_addr_e;
endpackage

// File: rtl/nmi_enable_reg.sv
// Holds the CPU-written interrupt enable bit and a one-cycle "late arm" flag.
// The late flag is raised when enable goes 0->1 by a write in the decision
// cycle (TRIGGER_CYCLE-1), so the trigger may fire one cycle later instead.
// Assumes: one write per cycle at most; h_pos advances by one per clock.
module nmi_enable_reg #(
    parameter int H_WIDTH       = 8,
    parameter int TRIGGER_CYCLE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [H_WIDTH-1:0] h_pos,
    input  logic               wr_en,
    input  logic               wr_data,
    output logic               en_q,
    output logic               late_q
);
    localparam logic [H_WIDTH-1:0] H_ARM = H_WIDTH'(TRIGGER_CYCLE - 1);

    // Enable register: loads the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= wr_data;
    end

    // Late arm: marks an enable that arrived exactly at the decision cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) late_q <= 1'b0;
        else        late_q <= wr_en && wr_data && !en_q && (h_pos == H_ARM);
    end
endmodule

// File: rtl/nmi_trigger.sv
// Decides, for the coming clock edge, whether a strobe must start.
// Normal arm at TRIGGER_CYCLE-1 uses the enable value held before any write
// in that cycle; the late arm fires at TRIGGER_CYCLE. Only these two cycles
// can fire, so a line yields at most one strobe.
// Assumes: TRIGGER_CYCLE >= 1 and fits in H_WIDTH bits.
module nmi_trigger #(
    parameter int H_WIDTH       = 8,
    parameter int TRIGGER_CYCLE = 8
) (
    input  logic [H_WIDTH-1:0] h_pos,
    input  logic               req,
    input  logic               en_q,
    input  logic               late_q,
    output logic               fire
);
    localparam logic [H_WIDTH-1:0] H_ARM  = H_WIDTH'(TRIGGER_CYCLE - 1);
    localparam logic [H_WIDTH-1:0] H_LATE = H_WIDTH'(TRIGGER_CYCLE);

    // Fire decision: on-time or one-cycle-late arm, gated by the request.
    always_comb begin
        fire = req && (((h_pos == H_ARM) && en_q) || ((h_pos == H_LATE) && late_q));
    end
endmodule

// File: rtl/nmi_pulse.sv
// Shapes the active-low strobe: low for exactly PULSE_CYCLES cycles after a
// fire edge, then released without any acknowledge.
// Assumes: fires are at least PULSE_CYCLES apart (one per scanline).
module nmi_pulse #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic nmi_n
);
    generate
        if (PULSE_CYCLES == 1) begin : g_single
            logic low_q;
            // Single-cycle strobe: one flop.
            always_ff @(posedge clk) begin
                if (!rst_n) low_q <= 1'b0;
                else        low_q <= fire;
            end
            assign nmi_n = !low_q;
        end else begin : g_count
            localparam int CW = $clog2(PULSE_CYCLES + 1);
            logic [CW-1:0] left_q;
            // Down-counter of remaining low cycles.
            always_ff @(posedge clk) begin
                if (!rst_n)              left_q <= '0;
                else if (fire)           left_q <= CW'(PULSE_CYCLES);
                else if (left_q != '0)   left_q <= left_q - 1'b1;
            end
            assign nmi_n = (left_q == '0);
        end
    endgenerate
endmodule

// File: rtl/nmi_status.sv
// Cause flag for the scanline source. Set by a fire, cleared by a write to
// the clear address; a coincident fire wins over the clear.
module nmi_status (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic flag_q
);
    // Cause latch with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (fire) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end
endmodule

// File: rtl/scanline_nmi_gen.sv
// Top: scanline interrupt strobe generator. Ties enable register, trigger,
// pulse shaper and status flag together and decodes the CPU write port.
// Assumes: h_pos counts one per clock and wraps at the line end.
module scanline_nmi_gen
    import scanline_nmi_pkg::*;
#(
    parameter int H_WIDTH       = 8,
    parameter int TRIGGER_CYCLE = 8,
    parameter int PULSE_CYCLES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [H_WIDTH-1:0] h_pos,
    input  logic               line_irq_req,
    input  logic               cpu_wr,
    input  logic               cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               nmi_n,
    output logic [DATA_W-1:0]  irq_status
);
    logic wr_enable, wr_clear;
    logic en_q, late_q, fire, flag_q;
    logic unused_wdata;

    // Write decode.
    always_comb begin
        wr_enable = cpu_wr && (wr_addr_e'(cpu_addr) == ADDR_ENABLE);
        wr_clear  = cpu_wr && (wr_addr_e'(cpu_addr) == ADDR_CLEAR);
    end

    assign unused_wdata = ^{cpu_wdata[EN_LINE_BIT-1:0]};

    nmi_enable_reg #(.H_WIDTH(H_WIDTH), .TRIGGER_CYCLE(TRIGGER_CYCLE)) u_en (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .wr_en(wr_enable),
        .wr_data(cpu_wdata[EN_LINE_BIT]), .en_q(en_q), .late_q(late_q)
    );

    nmi_trigger #(.H_WIDTH(H_WIDTH), .TRIGGER_CYCLE(TRIGGER_CYCLE)) u_trig (
        .h_pos(h_pos), .req(line_irq_req), .en_q(en_q), .late_q(late_q), .fire(fire)
    );

    nmi_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(fire), .nmi_n(nmi_n)
    );

    nmi_status u_stat (
        .clk(clk), .rst_n(rst_n), .fire(fire), .clr(wr_clear), .flag_q(flag_q)
    );

    // Status byte assembly: only the scanline cause is driven here.
    always_comb begin
        irq_status = '0;
        irq_status[STAT_LINE_BIT]  = flag_q;
        irq_status[STAT_FRAME_BIT] = 1'b0;
    end
endmodule

// File: rtl/scanline_nmi_gen_chk.sv
// Assertion checker for scanline_nmi_gen, attached by bind below.
// Watches only the top-level ports.
module scanline_nmi_gen_chk #(
    parameter int H_WIDTH       = 8,
    parameter int TRIGGER_CYCLE = 8,
    parameter int PULSE_CYCLES  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [H_WIDTH-1:0] h_pos,
    input logic               line_irq_req,
    input logic               cpu_wr,
    input logic               cpu_addr,
    input logic               nmi_n,
    input logic [7:0]         irq_status
);
    localparam int CW = $clog2(PULSE_CYCLES + 2);
    localparam logic [H_WIDTH-1:0] H_ARM  = H_WIDTH'(TRIGGER_CYCLE - 1);
    localparam logic [H_WIDTH-1:0] H_LATE = H_WIDTH'(TRIGGER_CYCLE);

    logic [CW-1:0] low_cnt;

    // Counts consecutive low cycles of the strobe seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!nmi_n) low_cnt <= low_cnt + 1'b1;
        else             low_cnt <= '0;
    end

    p_start_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |-> ($past(h_pos) == H_ARM || $past(h_pos) == H_LATE));

    p_start_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |-> $past(line_irq_req));

    p_no_long_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n |-> (int'(low_cnt) < PULSE_CYCLES));

    p_exact_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_n) |-> (int'(low_cnt) == PULSE_CYCLES));

    p_status_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |-> irq_status[7]);

    p_clear_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr && h_pos != H_ARM && h_pos != H_LATE) |=> !irq_status[7]);
endmodule

bind scanline_nmi_gen scanline_nmi_gen_chk #(
    .H_WIDTH(H_WIDTH), .TRIGGER_CYCLE(TRIGGER_CYCLE), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_irq_req(line_irq_req),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .nmi_n(nmi_n), .irq_status(irq_status)
);

// File: tb/test_scanline_nmi_gen.sv
// Sweep bench: every request/enable/write-kind/write-cycle combination,
// each cycle of each line compared against an arithmetic model.
module test_scanline_nmi_gen;
    localparam int HW = 8, T = 8, P = 2, LINE = 114;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] h_pos = '0;
    logic          line_irq_req = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
    logic [7:0]    cpu_wdata = '0;
    logic          nmi_n;
    logic [7:0]    irq_status;

    int  n_tests = 0, n_fail = 0;
    bit  done = 1'b0;
    bit  en_m = 1'b0, stat_m = 1'b0;

    always #10 clk = ~clk;

    scanline_nmi_gen #(.H_WIDTH(HW), .TRIGGER_CYCLE(T), .PULSE_CYCLES(P)) i_scanline_nmi_gen (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .line_irq_req(line_irq_req),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .nmi_n(nmi_n), .irq_status(irq_status)
    );

    task automatic check(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // init_en: -1 = no enable write, 0 = write 0x7F, 1 = write 0x80.
    // kind: 0 = write enable 0x7F, 1 = write enable 0xFF, 2 = clear status.
    task automatic run_line(bit req, int init_en, int wcyc, int kind);
        int  start_m = -1;
        bit  late = 1'b0;
        for (int h = 0; h < LINE; h++) begin
            bit    wr_en_b = 1'b0, wr_clr_b = 1'b0;
            bit    exp_low;
            string tag;
            @(negedge clk);
            h_pos = HW'(h); line_irq_req = req;
            cpu_wr = 1'b0; cpu_addr = 1'b0; cpu_wdata = 8'h00;
            if (h == 2 && init_en >= 0) begin
                cpu_wr = 1'b1; cpu_wdata = (init_en == 1) ? 8'h80 : 8'h7F; wr_en_b = 1'b1;
            end else if (h == wcyc) begin
                cpu_wr = 1'b1;
                if (kind == 2) begin cpu_addr = 1'b1; wr_clr_b = 1'b1; end
                else begin cpu_wdata = (kind == 1) ? 8'hFF : 8'h7F; wr_en_b = 1'b1; end
            end else if (h == 50) begin
                cpu_wr = 1'b1; cpu_addr = 1'b1; wr_clr_b = 1'b1;
            end
            // Expected outputs of this cycle
            exp_low = (start_m >= 0) && (h >= start_m) && (h < start_m + P);
            if (init_en < 0 && req)              tag = "R1";
            else if (start_m == T + 1)           tag = "R3";
            else if (exp_low)                    tag = "R2";
            else if (init_en == 0 && req && h >= T && h <= T + P) tag = "R8";
            else if (h >= T && h <= T + P)       tag = "R4";
            else                                 tag = "R5";
            check(tag, int'(nmi_n), exp_low ? 0 : 1, "nmi_n");
            check((h == 51 || h == wcyc + 1) ? "R7" : "R6", int'(irq_status[7]), int'(stat_m), "status bit7");
            check("R6", int'(irq_status[6:0]), 0, "status bits 6:0");
            // Model of the edge closing this cycle
            if (h == T - 1 && en_m && req) start_m = T;
            if (h == T && late && req)     start_m = T + 1;
            late = wr_en_b && cpu_wdata[7] && !en_m && (h == T - 1);
            if (wr_en_b)  en_m = cpu_wdata[7];
            if (wr_clr_b) stat_m = 1'b0;
            if (start_m == h + 1) stat_m = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(nmi_n), 1, "reset nmi_n");
        check("R1", int'(irq_status), 0, "reset status");
        rst_n = 1'b1;
        // R1: enable stays cleared after reset, requested line gives nothing
        run_line(1'b1, -1, -1, 0);
        for (int rq = 0; rq < 2; rq++)
            for (int ie = 0; ie < 2; ie++) begin
                run_line(rq[0], ie, -1, 0);
                for (int kd = 0; kd < 3; kd++)
                    for (int wc = T - 3; wc <= T + 1; wc++)
                        run_line(rq[0], ie, wc, kd);
            end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule